// File: doc/BRIEF.md
# Two-Wire Memory Slave Front End

This block is the serial side of a byte-addressed memory that answers on a two-wire bus. It runs on a fast system clock. It oversamples the raw SCL and SDA lines and finds START and STOP conditions. It receives the device-select byte and decides whether the transfer is addressed to it. It then turns the rest of the transfer into byte-level events for a memory core. Those events are a word-address load, a write-data strobe, a read-data request and a transaction-end pulse. The block pulls SDA low through an open-drain enable and never drives the line high.

The device-select byte has three layouts. The upper nibble must equal the fixed type code `1010`. Bit 0 gives the direction. The three bits in between are shared between chip-select pins and memory address bits. The parameter `HI_BITS` sets how many of them carry memory address bits; the rest are compared against the strapped pins. This lets one front end serve memories from 256 bytes to 2 KiB. Several smaller parts can then share one bus.

The memory core returns read bytes on `rd_data`. It must update `rd_data` in reaction to `rd_req` within a few system clocks. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_mem_slave`

## Requirements
- R1: After a synchronous reset, `sda_oe` is 0 and no strobe output (`word_load`, `wr_strobe`, `rd_req`, `xfer_end`) is active.
- R2: Bits clocked on the bus before any START produce no acknowledge and no strobe.
- R3: A select byte is accepted only when its bits 7..4 equal `1010`; otherwise the block does not acknowledge it.
- R4: Among select bits 3..1, the lowest `HI_BITS` are address bits. Each remaining bit k (k = 1..3) must equal `dev_pins[k-1]`. On a mismatch the block stays silent, with `sda_oe` 0, and ignores all bytes until the next START.
- R5: The select bits used as address bits become `word_addr[8 +: HI_BITS]`, with select bit 1 mapping to address bit 8.
- R6: The block pulls SDA low during the 9th SCL clock after a matching select byte. It does the same after every word-address byte and write-data byte.
- R7: In a write transfer, the first byte after the select byte pulses `word_load` for one cycle. The pulse carries `word_addr` = {select address bits, that byte}.
- R8: Each further byte of a write transfer pulses `wr_strobe` once with `wr_data` equal to that byte. At most one strobe output is active in any cycle.
- R9: Select bit 0 is 1 for a read and 0 for a write. In a read, `rd_req` pulses once on the select byte and once on every master acknowledge. The byte then on `rd_data` is sent MSB first. Incoming bits are sampled on rising SCL. `sda_oe` changes only while SCL is low. SDA is released on the 9th clock.
- R10: When the master does not acknowledge a read byte, the block stops driving and issues no further `rd_req`.
- R11: A START in the middle of a transfer, even partway through a byte, restarts bit counting and returns the block to the select-byte phase.
- R12: `xfer_end` pulses once on a STOP or START that ends a transfer whose select byte matched. It does not pulse otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (resolved bus level) |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_pins | input | 3 | Strapped chip-select pins, bit 0 = lowest pin; tie unused pins to 0 |
| word_load | output | 1 | One-cycle pulse: word address received |
| word_addr | output | 8+HI_BITS | Word address, valid with `word_load` |
| wr_strobe | output | 1 | One-cycle pulse: write byte received |
| wr_data | output | 8 | Write byte, valid with `wr_strobe` |
| rd_req | output | 1 | One-cycle pulse: present next read byte |
| rd_data | input | 8 | Read byte from the memory core |
| xfer_end | output | 1 | One-cycle pulse: addressed transfer ended |

## Verification
The hardest situation to reach from the ports is a START that lands inside a byte. By then the bit counter holds a partial count, and the shift register holds stale bits that must not leak into the next select byte. The bench reaches it by driving three bits of a byte after the select, then raising SCL and dropping SDA. It then checks that a fresh select byte and word address decode exactly. A second awkward case is the read NACK. The bench acknowledges several read bytes and refuses the last one. It then keeps clocking and checks that the line stays released and that no request follows. Every possible select byte is also swept against fixed pins to cover the match decode.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SEL,
    S_SEL_ACK,
    S_WADR,
    S_WADR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RDAT_ACK,
    S_SKIP
  } slv_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic scl;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output i2c_slv_pkg::bus_evt_t ev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh;
  logic [DEPTH-1:0] sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_now  = sda_sh[STAGES-1];
  assign sda_prev = sda_sh[STAGES];

  always_comb begin
    ev.scl      = scl_now;
    ev.sda      = sda_now;
    ev.scl_rise = scl_now & ~scl_prev;
    ev.scl_fall = ~scl_now & scl_prev;
    ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
    ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
  end

endmodule

// File: rtl/i2c_sel_match.sv
module i2c_sel_match #(
  parameter int          HI_BITS = 1,
  parameter logic [3:0]  TYPE_ID = 4'b1010,
  localparam int         HI_W    = (HI_BITS > 0) ? HI_BITS : 1
) (
  input  logic [7:0]      sel,
  input  logic [2:0]      pins,
  output logic            hit,
  output logic            is_read,
  output logic [HI_W-1:0] hi
);
  logic [2:0] bit_ok;

  for (genvar i = 0; i < 3; i++) begin : g_bit
    if (i < HI_BITS) begin : g_addr
      assign bit_ok[i] = 1'b1;
    end else begin : g_pin
      assign bit_ok[i] = (sel[i+1] == pins[i]);
    end
  end

  if (HI_BITS > 0) begin : g_hi
    assign hi = sel[HI_BITS:1];
  end else begin : g_nohi
    assign hi = 1'b0;
  end

  assign hit     = (sel[7:4] == TYPE_ID) && (&bit_ok);
  assign is_read = sel[0];

endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl #(
  parameter int  HI_BITS = 1,
  localparam int HI_W    = (HI_BITS > 0) ? HI_BITS : 1,
  localparam int ADDR_W  = 8 + HI_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  i2c_slv_pkg::bus_evt_t ev,
  input  logic [2:0]            pins,
  input  logic [7:0]            rd_data,
  output logic                  sda_oe,
  output logic                  word_load,
  output logic [ADDR_W-1:0]     word_addr,
  output logic                  wr_strobe,
  output logic [7:0]            wr_data,
  output logic                  rd_req,
  output logic                  xfer_end
);
  import i2c_slv_pkg::*;

  slv_state_e      st;
  logic [7:0]      sh;
  logic [2:0]      bcnt;
  logic            engaged;
  logic            rd_mode;
  logic            phase_b;
  logic [HI_W-1:0] hi_q;

  logic [7:0]      in_byte;
  logic            last_bit;
  logic            sel_hit, sel_rd;
  logic [HI_W-1:0] sel_hi;
  logic [HI_W+7:0] full_a;

  assign in_byte  = {sh[6:0], ev.sda};
  assign last_bit = (bcnt == 3'd7);
  assign full_a   = {hi_q, in_byte};

  i2c_sel_match #(.HI_BITS(HI_BITS)) u_match (
    .sel     (in_byte),
    .pins    (pins),
    .hit     (sel_hit),
    .is_read (sel_rd),
    .hi      (sel_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      sh        <= '0;
      bcnt      <= '0;
      engaged   <= 1'b0;
      rd_mode   <= 1'b0;
      phase_b   <= 1'b0;
      hi_q      <= '0;
      sda_oe    <= 1'b0;
      word_load <= 1'b0;
      word_addr <= '0;
      wr_strobe <= 1'b0;
      wr_data   <= '0;
      rd_req    <= 1'b0;
      xfer_end  <= 1'b0;
    end else begin
      word_load <= 1'b0;
      wr_strobe <= 1'b0;
      rd_req    <= 1'b0;
      xfer_end  <= 1'b0;
      if (ev.start) begin
        xfer_end <= engaged;
        engaged  <= 1'b0;
        st       <= S_SEL;
        bcnt     <= '0;
        phase_b  <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (ev.stop) begin
        xfer_end <= engaged;
        engaged  <= 1'b0;
        st       <= S_IDLE;
        phase_b  <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        case (st)
          S_SEL: begin
            if (ev.scl_rise) begin
              sh   <= in_byte;
              bcnt <= bcnt + 3'd1;
              if (last_bit) begin
                if (sel_hit) begin
                  engaged <= 1'b1;
                  hi_q    <= sel_hi;
                  rd_mode <= sel_rd;
                  rd_req  <= sel_rd;
                  st      <= S_SEL_ACK;
                end else begin
                  st <= S_SKIP;
                end
              end
            end
          end
          S_SEL_ACK, S_WADR_ACK, S_WDAT_ACK: begin
            if (ev.scl_fall) begin
              if (!phase_b) begin
                phase_b <= 1'b1;
                sda_oe  <= 1'b1;
              end else begin
                phase_b <= 1'b0;
                bcnt    <= '0;
                if (st == S_SEL_ACK && rd_mode) begin
                  sh     <= rd_data;
                  sda_oe <= ~rd_data[7];
                  st     <= S_RDAT;
                end else begin
                  sda_oe <= 1'b0;
                  st     <= (st == S_SEL_ACK) ? S_WADR : S_WDAT;
                end
              end
            end
          end
          S_WADR: begin
            if (ev.scl_rise) begin
              sh   <= in_byte;
              bcnt <= bcnt + 3'd1;
              if (last_bit) begin
                word_load <= 1'b1;
                word_addr <= full_a[ADDR_W-1:0];
                st        <= S_WADR_ACK;
              end
            end
          end
          S_WDAT: begin
            if (ev.scl_rise) begin
              sh   <= in_byte;
              bcnt <= bcnt + 3'd1;
              if (last_bit) begin
                wr_strobe <= 1'b1;
                wr_data   <= in_byte;
                st        <= S_WDAT_ACK;
              end
            end
          end
          S_RDAT: begin
            if (ev.scl_rise) begin
              bcnt <= bcnt + 3'd1;
              if (last_bit) st <= S_RDAT_ACK;
            end else if (ev.scl_fall) begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
          S_RDAT_ACK: begin
            if (ev.scl_fall) begin
              if (!phase_b) begin
                sda_oe <= 1'b0;
              end else begin
                phase_b <= 1'b0;
                bcnt    <= '0;
                sh      <= rd_data;
                sda_oe  <= ~rd_data[7];
                st      <= S_RDAT;
              end
            end else if (ev.scl_rise) begin
              if (!ev.sda) begin
                rd_req  <= 1'b1;
                phase_b <= 1'b1;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !ev.scl);

  // R4
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_SKIP) |-> !sda_oe);

  // R12
  end_clears_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> !engaged);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({word_load, wr_strobe, rd_req, xfer_end}));

  // R10
  nack_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_SKIP) |-> !rd_req);

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int  HI_BITS     = 1,
  parameter int  SYNC_STAGES = 2,
  localparam int ADDR_W      = 8 + HI_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_pins,
  output logic              word_load,
  output logic [ADDR_W-1:0] word_addr,
  output logic              wr_strobe,
  output logic [7:0]        wr_data,
  output logic              rd_req,
  input  logic [7:0]        rd_data,
  output logic              xfer_end
);
  i2c_slv_pkg::bus_evt_t ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (ev)
  );

  i2c_slv_ctrl #(.HI_BITS(HI_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .pins      (dev_pins),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .word_load (word_load),
    .word_addr (word_addr),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .xfer_end  (xfer_end)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe && !word_load && !wr_strobe && !rd_req && !xfer_end));

endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int HI_BITS = 1;
  localparam int ADDR_W  = 8 + HI_BITS;
  localparam int H       = 8;
  localparam logic [2:0] PINS = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, word_load, wr_strobe, rd_req, xfer_end;
  logic [ADDR_W-1:0] word_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_mem_slave #(.HI_BITS(HI_BITS)) i_i2c_mem_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_pins(PINS), .word_load(word_load), .word_addr(word_addr),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .xfer_end(xfer_end)
  );

  int n_chk = 0, n_fail = 0;
  int n_wl = 0, n_wr = 0, n_rq = 0, n_end = 0;
  logic [ADDR_W-1:0] last_wa;
  logic [7:0] last_wd;

  function automatic logic [7:0] rdv(input int k);
    return 8'((k * 53 + 29) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst) begin
      if (word_load) begin n_wl <= n_wl + 1; last_wa <= word_addr; end
      if (wr_strobe) begin n_wr <= n_wr + 1; last_wd <= wr_data; end
      if (rd_req) begin rd_data <= rdv(n_rq); n_rq <= n_rq + 1; end
      if (xfer_end) n_end <= n_end + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wc(5); scl_m = 1'b1; wc(H); sda_m = 1'b0; wc(H); scl_m = 1'b0; wc(2);
  endtask

  task automatic bus_stop();
    wc(5); sda_m = 1'b0; wc(5); scl_m = 1'b1; wc(H); sda_m = 1'b1; wc(H);
  endtask

  task automatic put_bit(input logic b);
    wc(5); sda_m = b; wc(5); scl_m = 1'b1; wc(H); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wc(5); sda_m = 1'b1; wc(5); scl_m = 1'b1; wc(4); b = sda_line; wc(4); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~give_ack);
  endtask

  initial begin : main
    logic ack;
    logic [7:0] d;
    int rd_idx, ends_exp, wr_base, rq_base;
    wc(6);
    rst = 1'b0;
    wc(2);
    // R1: reset state
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    chk({word_load, wr_strobe, rd_req, xfer_end} == 4'b0, "R1",
        {word_load, wr_strobe, rd_req, xfer_end}, 0);

    // R2: bits before any START are ignored
    scl_m = 1'b0; wc(4);
    send_byte(8'hA8, ack);
    chk(ack == 1'b0, "R2", ack, 0);
    chk(n_wl + n_wr + n_rq + n_end == 0, "R2", n_wl + n_wr + n_rq + n_end, 0);
    wc(5); sda_m = 1'b1; scl_m = 1'b1; wc(H);

    // R3 R4: sweep every select byte against pins 101
    rd_idx = 0; ends_exp = 0;
    for (int s = 0; s < 256; s++) begin
      logic [7:0] sb;
      logic exp_ack;
      sb = 8'(s);
      exp_ack = (sb[7:4] == 4'hA) && (sb[3] == PINS[2]) && (sb[2] == PINS[1]);
      bus_start();
      send_byte(sb, ack);
      chk(ack == exp_ack, (sb[7:4] == 4'hA) ? "R4" : "R3", ack, exp_ack);
      if (exp_ack && sb[0]) begin
        // R9: first read byte after select
        recv_byte(d, 1'b0);
        chk(d == rdv(rd_idx), "R9", d, rdv(rd_idx));
        rd_idx++;
      end
      bus_stop();
      if (exp_ack) ends_exp++;
    end
    chk(n_end == ends_exp, "R12", n_end, ends_exp);
    chk(n_rq == rd_idx, "R9", n_rq, rd_idx);

    // R4: after a mismatch, later bytes without START are ignored
    bus_start();
    send_byte(8'h50, ack);
    chk(ack == 1'b0, "R3", ack, 0);
    send_byte(8'hA8, ack);
    chk(ack == 1'b0, "R4", ack, 0);
    bus_stop();

    // R5 R6 R7 R8: writes with both values of the select address bit
    for (int h = 0; h < 2; h++) begin
      bus_start();
      send_byte(8'hA8 | 8'(h << 1), ack);
      chk(ack, "R6", ack, 1);
      send_byte(8'h5C, ack);
      chk(ack, "R6", ack, 1);
      chk(last_wa == ADDR_W'((h << 8) | 8'h5C), "R5", last_wa, (h << 8) | 8'h5C);
      for (int k = 0; k < 3; k++) begin
        logic [7:0] wv;
        wr_base = n_wr;
        wv = 8'(8'h11 * (k + 1) + h);
        send_byte(wv, ack);
        chk(ack, "R6", ack, 1);
        chk(n_wr == wr_base + 1 && last_wd == wv, "R8", last_wd, wv);
      end
      ends_exp = n_end;
      bus_stop();
      wc(4);
      chk(n_end == ends_exp + 1, "R12", n_end, ends_exp + 1);
    end
    chk(n_wl >= 2, "R7", n_wl, 2);

    // R9 R10: multi-byte read, acknowledge three, refuse the fourth
    rq_base = n_rq;
    bus_start();
    send_byte(8'hA9, ack);
    chk(ack, "R9", ack, 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(d, k < 3);
      chk(d == rdv(rq_base + k), "R9", d, rdv(rq_base + k));
    end
    wc(2);
    chk(n_rq == rq_base + 4, "R10", n_rq, rq_base + 4);
    get_bit(d[0]);
    chk(d[0] == 1'b1, "R10", d[0], 1);
    bus_stop();
    chk(n_rq == rq_base + 4, "R10", n_rq, rq_base + 4);

    // R11 R12: repeated START after word address, then read
    ends_exp = n_end;
    wr_base = n_wr;
    bus_start();
    send_byte(8'hA8, ack);
    send_byte(8'h33, ack);
    bus_start();
    chk(n_end == ends_exp + 1, "R12", n_end, ends_exp + 1);
    send_byte(8'hA9, ack);
    chk(ack, "R11", ack, 1);
    recv_byte(d, 1'b0);
    bus_stop();
    chk(n_end == ends_exp + 2, "R12", n_end, ends_exp + 2);
    chk(n_wr == wr_base, "R11", n_wr, wr_base);

    // R11: START in the middle of a byte restarts bit counting
    bus_start();
    send_byte(8'hAA, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(8'hAA, ack);
    chk(ack, "R11", ack, 1);
    send_byte(8'h77, ack);
    chk(last_wa == ADDR_W'(9'h177), "R11", last_wa, 9'h177);
    bus_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule